// File: doc/BRIEF.md
# Multi-Format Signed Adder/Subtractor

This block adds or subtracts two N-bit signed operands held in one of three encodings: sign-and-magnitude, one's complement or two's complement. A two-bit format input chooses the encoding for both operands and for the result. A subtract input makes the block compute A minus B instead of A plus B. The result comes back in the same encoding, together with a flag that is raised when the true result does not fit.

The arithmetic is combinational. One register stage at the output captures the result and the flag, so a result appears one clock after its operands are presented. A new operation may start every cycle. Each format has its own arithmetic unit. The format input only chooses which unit's result is kept, so a format can be changed from one cycle to the next with no penalty.

Top module: `numfmt_addsub`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `sum_q` and `ovf_q` are cleared to zero. After reset, both outputs show the result for the operands sampled at the previous rising edge.
- R2: The format codes are: `fmt` 2'b00 for sign-and-magnitude (bit N-1 is the sign, bits N-2:0 the magnitude), 2'b01 for one's complement, and 2'b10 for two's complement. The code 2'b11 also selects two's complement.
- R3: In sign-and-magnitude, when the signs (after any subtract negation) agree, the magnitudes are summed and the common sign is kept. `ovf_q` is raised when that sum exceeds 2^(N-1)-1, and the result then keeps the low N-1 bits of the sum.
- R4: In sign-and-magnitude, when the signs differ, the smaller magnitude is taken from the larger and the result takes the sign of the larger. `ovf_q` stays low. A zero magnitude always comes out with sign 0.
- R5: In sign-and-magnitude, subtraction inverts the sign bit of B and then follows R3 or R4.
- R6: In one's complement, addition feeds the carry out of bit N-1 back into bit 0. Subtraction adds the bitwise complement of B.
- R7: In one's complement, an all-ones result (negative zero) is returned as all zeros.
- R8: In one's complement, `ovf_q` is raised when both addends (B after any negation) share a sign and the end-around result has the other sign.
- R9: In two's complement, the carry out of bit N-1 is dropped. Subtraction adds the bitwise complement of B plus one.
- R10: In two's complement, `ovf_q` is raised exactly when the carry into bit N-1 differs from the carry out of it. Adding two operands of opposite sign never overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | N | First operand (minuend) |
| op_b | input | N | Second operand (subtrahend when subtracting) |
| sub | input | 1 | 1: A minus B, 0: A plus B |
| fmt | input | 2 | Number encoding of operands and result |
| sum_q | output | N | Registered result in the selected encoding |
| ovf_q | output | 1 | Registered overflow flag |

## Verification
Two things can happen in the same operation: a negative-zero encoding is normalised, and a carry or sign correction is applied. In one's complement, the end-around carry can produce an all-ones word that must then be folded to zero. In sign-and-magnitude, subtracting equal magnitudes produces a zero that must come out positive. The bench provokes both with directed cases such as 3-3, -0 + -0 and +0 - +0. It also checks wrapped results on overflow, where the carry logic and the flag act together. Every result is compared, word and flag, with an integer model that decodes the operands, computes the exact sum and re-encodes it for the selected format.

// File: rtl/numfmt_pkg.sv
// Package: shared format encoding for the multi-format adder/subtractor.
// Assumes the two-bit format code is decoded identically everywhere.
package numfmt_pkg;
    typedef enum logic [1:0] {
        FMT_SIGNMAG  = 2'b00,
        FMT_ONES     = 2'b01,
        FMT_TWOS     = 2'b10,
        FMT_TWOS_ALT = 2'b11
    } fmt_e;
endpackage

// File: rtl/signmag_unit.sv
// Sign-and-magnitude add/subtract. Purely combinational.
// Assumes W >= 2; bit W-1 is the sign and the remaining bits are the magnitude.
// A zero magnitude result is always returned as positive zero.
module signmag_unit #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int MW = W - 1;

    logic          sgn_a, sgn_b;
    logic [MW-1:0] mag_a, mag_b;
    logic [MW:0]   mag_sum;
    logic [MW-1:0] mag_out;
    logic          sgn_out;

    // Split the operands; subtraction flips the sign of B.
    always_comb begin
        sgn_a = a[W-1];
        sgn_b = b[W-1] ^ sub;
        mag_a = a[MW-1:0];
        mag_b = b[MW-1:0];
    end

    // Same sign: add magnitudes. Different signs: larger minus smaller.
    always_comb begin
        mag_sum = {1'b0, mag_a} + {1'b0, mag_b};
        if (sgn_a == sgn_b) begin
            mag_out = mag_sum[MW-1:0];
            sgn_out = sgn_a;
            ovf     = mag_sum[MW];
        end else if (mag_a >= mag_b) begin
            mag_out = mag_a - mag_b;
            sgn_out = sgn_a;
            ovf     = 1'b0;
        end else begin
            mag_out = mag_b - mag_a;
            sgn_out = sgn_b;
            ovf     = 1'b0;
        end
    end

    // Normalise a zero magnitude to positive zero.
    always_comb begin
        res = {sgn_out & (|mag_out), mag_out};
    end
endmodule

// File: rtl/compl_unit.sv
// Complement-code add/subtract. Purely combinational.
// END_AROUND=1 gives one's complement: bitwise negation, end-around carry,
// negative zero folded to zero, and a sign-rule overflow flag.
// END_AROUND=0 gives two's complement: negation is complement plus one, the
// carry out is dropped, and overflow compares the carries into and out of the sign bit.
// Assumes W >= 2.
module compl_unit #(
    parameter int W          = 8,
    parameter bit END_AROUND = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         cin;
    logic [W:0]   raw;

    // Negate B by complementing it; the +1 of two's complement enters as carry-in.
    always_comb begin
        b_eff = sub ? ~b : b;
        cin   = END_AROUND ? 1'b0 : sub;
        raw   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    end

    generate
        if (END_AROUND) begin : g_ones
            logic [W-1:0] wrapped;
            // Add the carry back in at bit 0. This cannot carry a second time.
            always_comb begin
                wrapped = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
                ovf     = (a[W-1] == b_eff[W-1]) && (wrapped[W-1] != a[W-1]);
                res     = (&wrapped) ? '0 : wrapped;
            end
        end else begin : g_twos
            logic [W-1:0] low;
            // Carry into the sign bit, from a sum of the lower bits only.
            always_comb begin
                low = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, cin};
                ovf = low[W-1] ^ raw[W];
                res = raw[W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/numfmt_addsub.sv
// Top: multi-format signed adder/subtractor with one output register stage.
// Each format has its own unit. The format code picks one unit's result, which is
// registered with the overflow flag. Latency is one cycle and throughput one per cycle.
// Reset is synchronous and active low.
module numfmt_addsub #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic         sub,
    input  logic [1:0]   fmt,
    output logic [N-1:0] sum_q,
    output logic         ovf_q
);
    import numfmt_pkg::*;

    logic [N-1:0] sm_res, oc_res, tc_res;
    logic         sm_ovf, oc_ovf, tc_ovf;
    logic [N-1:0] sel_res;
    logic         sel_ovf;
    fmt_e         fmt_sel;

    signmag_unit #(.W(N)) u_sm (
        .a(op_a), .b(op_b), .sub(sub), .res(sm_res), .ovf(sm_ovf)
    );

    compl_unit #(.W(N), .END_AROUND(1'b1)) u_ones (
        .a(op_a), .b(op_b), .sub(sub), .res(oc_res), .ovf(oc_ovf)
    );

    compl_unit #(.W(N), .END_AROUND(1'b0)) u_twos (
        .a(op_a), .b(op_b), .sub(sub), .res(tc_res), .ovf(tc_ovf)
    );

    // Choose the unit matching the format code; both upper codes mean two's complement.
    always_comb begin
        fmt_sel = fmt_e'(fmt);
        case (fmt_sel)
            FMT_SIGNMAG: begin sel_res = sm_res; sel_ovf = sm_ovf; end
            FMT_ONES:    begin sel_res = oc_res; sel_ovf = oc_ovf; end
            default:     begin sel_res = tc_res; sel_ovf = tc_ovf; end
        endcase
    end

    // Output register stage, cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            sum_q <= sel_res;
            ovf_q <= sel_ovf;
        end
    end

    // R1: the cycle after reset is sampled low, both outputs are zero.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sum_q == '0 && !ovf_q));

    // R4: a sign-and-magnitude result with zero magnitude is never negative.
    a_r4_sm_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt) == 2'b00 && sum_q[N-2:0] == '0) |-> !sum_q[N-1]);

    // R4: sign-and-magnitude with differing effective signs never overflows.
    a_r4_sm_mixed_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt) == 2'b00 &&
         $past(op_a[N-1]) != ($past(op_b[N-1]) ^ $past(sub))) |-> !ovf_q);

    // R7: one's complement never returns negative zero.
    a_r7_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt) == 2'b01) |-> (sum_q != '1));

    // R10: two's complement addition of opposite-sign operands never overflows.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt[1]) && !$past(sub) && $past(op_a[N-1]) != $past(op_b[N-1]))
        |-> !ovf_q);

    // R10: when two's complement overflows, the result sign differs from A's sign.
    a_r10_ovf_sign: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fmt[1]) && ovf_q) |-> (sum_q[N-1] != $past(op_a[N-1])));
endmodule

// File: tb/numfmt_addsub_tb.sv
module numfmt_addsub_tb;
    localparam int N  = 8;
    localparam int HI = (1 << (N-1)) - 1;
    localparam int P  = 1 << N;
    localparam int M  = P - 1;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] op_a, op_b;
    logic         sub;
    logic [1:0]   fmt;
    logic [N-1:0] sum_q;
    logic         ovf_q;

    int total  = 0;
    int failed = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    numfmt_addsub #(.N(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .sub(sub), .fmt(fmt), .sum_q(sum_q), .ovf_q(ovf_q)
    );

    // Decode a word into its integer value, following the R2 encoding.
    function automatic int decode(input logic [N-1:0] x, input logic [1:0] f);
        logic [N-1:0] nx;
        nx = ~x;
        if (f == 2'b00)      return x[N-1] ? -int'(x[N-2:0]) : int'(x[N-2:0]);
        else if (f == 2'b01) return x[N-1] ? -int'(nx) : int'(x);
        else                 return x[N-1] ? int'(x) - P : int'(x);
    endfunction

    // Expected {ovf, result} built from the exact sum (R3 to R10).
    function automatic logic [N:0] expect_of(input logic [N-1:0] a, input logic [N-1:0] b,
                                             input logic s, input logic [1:0] f);
        int r, mag, v;
        logic o;
        r = s ? decode(a, f) - decode(b, f) : decode(a, f) + decode(b, f);
        if (f == 2'b00) begin
            o   = (r > HI) || (r < -HI);
            mag = (r < 0 ? -r : r) % (1 << (N-1));
            v   = ((mag != 0) && (r < 0)) ? mag + (1 << (N-1)) : mag;
        end else if (f == 2'b01) begin
            o = (r > HI) || (r < -HI);
            v = ((r % M) + M) % M;
        end else begin
            o = (r > HI) || (r < -(HI + 1));
            v = ((r % P) + P) % P;
        end
        return {o, v[N-1:0]};
    endfunction

    task automatic check(input string tag, input logic [N-1:0] got_r, input logic got_o,
                         input logic [N-1:0] exp_r, input logic exp_o);
        total++;
        if (got_r !== exp_r || got_o !== exp_o) begin
            failed++;
            $display("FAIL %s: got res=%h ovf=%b, expected res=%h ovf=%b",
                     tag, got_r, got_o, exp_r, exp_o);
        end
    endtask

    // Drive on a falling edge, then check on the next falling edge (one register).
    task automatic run(input logic [N-1:0] a, input logic [N-1:0] b, input logic s,
                       input logic [1:0] f, input string tag);
        logic [N:0] e;
        @(negedge clk);
        op_a = a; op_b = b; sub = s; fmt = f;
        e = expect_of(a, b, s, f);
        @(negedge clk);
        check(tag, sum_q, ovf_q, e[N-1:0], e[N]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_a = 8'h5A; op_b = 8'h33; sub = 1'b0; fmt = 2'b10;
        repeat (3) @(negedge clk);
        check("R1 reset", sum_q, ovf_q, '0, 1'b0);
        rst_n = 1'b1;

        // Sign-and-magnitude
        run(8'h05, 8'h03, 1'b0, 2'b00, "R3 5+3");
        run(8'h64, 8'h64, 1'b0, 2'b00, "R3 100+100 overflow");
        run(8'hE4, 8'hE4, 1'b0, 2'b00, "R3 -100+-100 overflow");
        run(8'h40, 8'h40, 1'b0, 2'b00, "R3 64+64 wraps to +0");
        run(8'h03, 8'h85, 1'b0, 2'b00, "R4 3+-5");
        run(8'h05, 8'h05, 1'b1, 2'b00, "R4 R5 5-5 positive zero");
        run(8'h80, 8'h80, 1'b0, 2'b00, "R4 -0+-0");
        run(8'h83, 8'h04, 1'b1, 2'b00, "R5 -3-4");
        run(8'h00, 8'h00, 1'b1, 2'b00, "R5 +0-+0");
        // One's complement
        run(8'hFC, 8'hFB, 1'b0, 2'b01, "R6 -3+-4 end-around");
        run(8'h03, 8'h03, 1'b1, 2'b01, "R6 R7 3-3");
        run(8'hFF, 8'hFF, 1'b0, 2'b01, "R7 -0+-0");
        run(8'h64, 8'h64, 1'b0, 2'b01, "R8 100+100 overflow");
        run(8'h81, 8'h81, 1'b0, 2'b01, "R8 -126+-126 overflow");
        // Two's complement
        run(8'h05, 8'hFD, 1'b0, 2'b10, "R9 5+-3 carry dropped");
        run(8'h02, 8'h05, 1'b1, 2'b10, "R9 2-5");
        run(8'h7F, 8'h01, 1'b0, 2'b10, "R10 127+1 overflow");
        run(8'h80, 8'h01, 1'b1, 2'b10, "R10 -128-1 overflow");
        run(8'h00, 8'h80, 1'b1, 2'b10, "R10 0-(-128) overflow");
        run(8'h80, 8'h80, 1'b1, 2'b10, "R9 -128-(-128)");
        run(8'h7F, 8'h80, 1'b0, 2'b10, "R10 mixed signs");
        run(8'h7F, 8'h01, 1'b0, 2'b11, "R2 code 11 as two's");
        run(8'h05, 8'h05, 1'b1, 2'b01, "R2 code 01 as one's");

        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] f;
            f = 2'($urandom());
            run(N'($urandom()), N'($urandom()), 1'($urandom()), f,
                f == 2'b00 ? "R3 R4 R5 random" :
                f == 2'b01 ? "R6 R7 R8 random" : "R9 R10 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule